// File: doc/BRIEF.md
# Capture-Compare Timer Channel with Handshake-Cleared Status Flags

This block is one timer channel built around a free-running up-counter and one general register. Software picks the role of that register with a mode bit. In compare mode, the general register holds a value, and a status flag rises when the counter reaches it. In capture mode, a rising edge on an external capture pin copies the counter into the general register and raises the same flag. The channel also has a second, compare-only register with its own match flag, and an overflow flag that rises when the counter wraps.

Software reaches the block through a plain register bus with an address, a read strobe, a write strobe and data in both directions. Read data follows the address combinationally. A status flag does not clear on a bare write. Software must first read the flag while it holds 1, and then write 0 to that bit. Each flag has its own "seen set" latch to track this. Any write to the status register drops the latch, whatever value is written. A single interrupt line is the OR of every flag gated by its enable bit.

Top module: `cctimer_chan`

## Requirements
- R1: While reset is asserted, and until the first clock edge after its release, every readable register and every flag reads 0. The mode bit selects compare, and `irq` is 0.
- R2: The counter (address 0) advances by one each clock and wraps from all-ones to 0. The wrap sets the overflow flag, which is bit 8 of the second status register at address 6. The flag sets on the same edge that loads 0 into the counter.
- R3: In capture mode, a rising edge on `cap_in` is resynchronised through two flip-flops. The counter value present two clocks after the pin rises is then loaded into the general register at address 1. On that same edge, the general flag (bit 0 of the first status register at address 5) sets.
- R4: In compare mode, the general flag sets on the edge after a cycle in which the counter equals the general register. In this mode `cap_in` has no effect on the general register.
- R5: The compare-only register at address 2 sets the secondary match flag (bit 0 of address 6) on the edge after a cycle in which the counter equals it.
- R6: A flag clears when software first reads its status register while the flag is 1, and then writes 0 to that bit.
- R7: A 0 written to a flag leaves the flag at 1 if there was no read since the last write to that register. A read that returned 0 for the flag does not count.
- R8: Writing 1 to a flag leaves it unchanged. Any write to a status register cancels pending reads, so a later 0 does not clear a flag without a fresh read.
- R9: Bits 15..9 and 7..1 of address 6, and bits 15..1 of address 5, always read 0 whatever has been written.
- R10: If a set event and a valid clear reach a flag on the same edge, the flag ends at 1.
- R11: `irq` is the OR of each flag ANDed with its enable bit in address 4: bit 0 for the general flag, bit 1 for the secondary match flag, bit 2 for overflow.
- R12: Bit 0 of the control register at address 3 selects capture mode when 1 and compare mode when 0. The other bits of that register read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Register address |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for the register at `addr` |
| cap_in | input | 1 | Asynchronous capture pin, rising edge active |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the clear handshake from several sides:
- A bare 0 write must not clear a flag; a design that cleared on it would lose events.
- A read that returned 0 must not arm the clear; a design that armed on it would drop a flag set later.
- A write of 1 must disarm the clear; otherwise a late 0 would clear without a fresh read.
- A clear that lands on the same edge as a capture must leave the flag set.

The bench also times the capture delay through the synchroniser to the exact cycle, so one flip-flop too few or too many shows up as a wrong captured count. It checks that the overflow flag rises exactly at the wrap and not one cycle early. It sweeps all eight interrupt enable patterns against known flag states.

// File: rtl/cctimer_pkg.sv
package cctimer_pkg;

   // Register addresses (low three bits of the bus address)
   typedef enum logic [2:0] {
      RA_CNT   = 3'd0,
      RA_GREG  = 3'd1,
      RA_CMPB  = 3'd2,
      RA_CTRL  = 3'd3,
      RA_IEN   = 3'd4,
      RA_STATA = 3'd5,
      RA_STATB = 3'd6
   } reg_addr_e;

   localparam int unsigned FLAG_NUM = 3;
   localparam int unsigned FLG_GEN  = 0;  // capture/compare flag of the general register
   localparam int unsigned FLG_CMB  = 1;  // compare-only register match
   localparam int unsigned FLG_OVF  = 2;  // counter wrap
   localparam int unsigned OVF_BIT  = 8;  // overflow position inside status register B

   // bit position of a flag inside its status register
   function automatic int unsigned flag_bit(input int unsigned f);
      return (f == FLG_OVF) ? OVF_BIT : 0;
   endfunction

   // status register holding a flag
   function automatic reg_addr_e flag_reg(input int unsigned f);
      return (f == FLG_GEN) ? RA_STATA : RA_STATB;
   endfunction

endpackage

// File: rtl/cctimer_counter.sv
module cctimer_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] cnt_o,
   output logic         wrap_o
);
   localparam logic [W-1:0] TOP = '1;

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o  = cnt_q;
   // high in the cycle before the counter returns to zero
   assign wrap_o = (cnt_q == TOP);
endmodule

// File: rtl/cctimer_edge.sv
module cctimer_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cctimer_edge: STAGES must be at least 2");
   end

   // STAGES synchroniser flops plus one history flop for edge detection
   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], async_i};
   end

   assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/cctimer_flag.sv
module cctimer_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic rd_i,
   input  logic wr_i,
   input  logic wbit_i,
   output logic flag_o,
   output logic arm_o
);
   logic flag_q, arm_q, clr;

   assign clr = wr_i & ~wbit_i & arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         if (wr_i)               arm_q <= 1'b0;
         else if (rd_i && flag_q) arm_q <= 1'b1;
         flag_q <= set_i | (flag_q & ~clr);
      end
   end

   assign flag_o = flag_q;
   assign arm_o  = arm_q;
endmodule

// File: rtl/cctimer_chan.sv
module cctimer_chan
   import cctimer_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              cap_in,
   output logic              irq
);
   localparam int unsigned CW = CNT_W;

   if (DATA_W < OVF_BIT + 1) begin : g_bad_dw
      $error("cctimer_chan: DATA_W too narrow for the overflow bit");
   end
   if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cw
      $error("cctimer_chan: CNT_W must lie in 2..DATA_W");
   end
   if (ADDR_W < 3) begin : g_bad_aw
      $error("cctimer_chan: ADDR_W must be at least 3");
   end

   // ---------------- address decode ----------------
   logic sel_cnt, sel_greg, sel_cmpb, sel_ctrl, sel_ien, sel_sta, sel_stb;
   assign sel_cnt  = (addr == ADDR_W'(RA_CNT));
   assign sel_greg = (addr == ADDR_W'(RA_GREG));
   assign sel_cmpb = (addr == ADDR_W'(RA_CMPB));
   assign sel_ctrl = (addr == ADDR_W'(RA_CTRL));
   assign sel_ien  = (addr == ADDR_W'(RA_IEN));
   assign sel_sta  = (addr == ADDR_W'(RA_STATA));
   assign sel_stb  = (addr == ADDR_W'(RA_STATB));

   // ---------------- counter and capture edge ----------------
   logic [CW-1:0] cnt_q;
   logic          wrap;
   logic          cap_stb;

   cctimer_counter #(.W(CW)) i_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt_o (cnt_q),
      .wrap_o(wrap)
   );

   cctimer_edge #(.STAGES(SYNC_STAGES)) i_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(cap_in),
      .rise_o (cap_stb)
   );

   // ---------------- configuration registers ----------------
   logic [CW-1:0]       greg_q, cmpb_q;
   logic                mode_q;       // 1 = capture, 0 = compare
   logic [FLAG_NUM-1:0] ien_q;
   logic                greg_wr;

   assign greg_wr = wr_en & sel_greg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         greg_q <= '0;
         cmpb_q <= '0;
         mode_q <= 1'b0;
         ien_q  <= '0;
      end else begin
         if (mode_q && cap_stb) greg_q <= cnt_q;
         else if (greg_wr)      greg_q <= wdata[CW-1:0];
         if (wr_en && sel_cmpb) cmpb_q <= wdata[CW-1:0];
         if (wr_en && sel_ctrl) mode_q <= wdata[0];
         if (wr_en && sel_ien)  ien_q  <= wdata[FLAG_NUM-1:0];
      end
   end

   // ---------------- flag set sources ----------------
   logic [FLAG_NUM-1:0] set_vec, flag_q, arm_q;

   always_comb begin
      set_vec          = '0;
      set_vec[FLG_GEN] = mode_q ? cap_stb : (cnt_q == greg_q);
      set_vec[FLG_CMB] = (cnt_q == cmpb_q);
      set_vec[FLG_OVF] = wrap;
   end

   // ---------------- handshake-cleared flags ----------------
   for (genvar i = 0; i < FLAG_NUM; i++) begin : g_flag
      localparam int unsigned BITPOS = flag_bit(i);
      localparam reg_addr_e   REGSEL = flag_reg(i);
      logic hit;
      assign hit = (addr == ADDR_W'(REGSEL));

      cctimer_flag i_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_vec[i]),
         .rd_i  (rd_en & hit),
         .wr_i  (wr_en & hit),
         .wbit_i(wdata[BITPOS]),
         .flag_o(flag_q[i]),
         .arm_o (arm_q[i])
      );
   end

   // ---------------- read mux and interrupt ----------------
   always_comb begin
      rdata = '0;
      unique case (1'b1)
         sel_cnt:  rdata[CW-1:0] = cnt_q;
         sel_greg: rdata[CW-1:0] = greg_q;
         sel_cmpb: rdata[CW-1:0] = cmpb_q;
         sel_ctrl: rdata[0] = mode_q;
         sel_ien:  rdata[FLAG_NUM-1:0] = ien_q;
         sel_sta:  rdata[flag_bit(FLG_GEN)] = flag_q[FLG_GEN];
         sel_stb: begin
            rdata[flag_bit(FLG_CMB)] = flag_q[FLG_CMB];
            rdata[flag_bit(FLG_OVF)] = flag_q[FLG_OVF];
         end
         default:  rdata = '0;
      endcase
   end

   assign irq = |(flag_q & ien_q);

endmodule

// File: rtl/cctimer_chan_chk.sv
module cctimer_chan_chk
   import cctimer_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic [CNT_W-1:0]    cnt_q,
   input logic [CNT_W-1:0]    greg_q,
   input logic [CNT_W-1:0]    cmpb_q,
   input logic                mode_q,
   input logic                cap_stb,
   input logic                greg_wr,
   input logic [FLAG_NUM-1:0] flag_q,
   input logic [FLAG_NUM-1:0] arm_q,
   input logic [ADDR_W-1:0]   addr,
   input logic [DATA_W-1:0]   rdata,
   input logic                irq
);
   localparam logic [CNT_W-1:0]  TOP    = '1;
   localparam logic [DATA_W-1:0] STB_OK = DATA_W'((1 << OVF_BIT) | 1);

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> cnt_q == $past(cnt_q) + 1'b1);

   // R2
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == TOP) |=> flag_q[FLG_OVF]);

   // R3
   capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && cap_stb) |=> (greg_q == $past(cnt_q)) && flag_q[FLG_GEN]);

   // R4
   compare_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && cnt_q == greg_q) |=> flag_q[FLG_GEN]);

   // R4
   compare_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && !greg_wr) |=> $stable(greg_q));

   // R5
   cmpb_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == cmpb_q) |=> flag_q[FLG_CMB]);

   for (genvar i = 0; i < FLAG_NUM; i++) begin : g_hold
      // R7
      unarmed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q[i] && !arm_q[i]) |=> flag_q[i]);
   end

   // R11
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q == '0) |-> !irq);

   // R9
   resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(RA_STATB)) |-> ((rdata & ~STB_OK) == '0));
endmodule

bind cctimer_chan cctimer_chan_chk #(
   .CNT_W (CNT_W),
   .DATA_W(DATA_W),
   .ADDR_W(ADDR_W)
) i_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cnt_q  (cnt_q),
   .greg_q (greg_q),
   .cmpb_q (cmpb_q),
   .mode_q (mode_q),
   .cap_stb(cap_stb),
   .greg_wr(greg_wr),
   .flag_q (flag_q),
   .arm_q  (arm_q),
   .addr   (addr),
   .rdata  (rdata),
   .irq    (irq)
);

// File: tb/test_cctimer_chan.sv
`timescale 1ns/1ps
module test_cctimer_chan;
   localparam int CW = 8;
   localparam int DW = 16;
   localparam int AW = 3;
   localparam int MASK = (1 << CW) - 1;

   localparam int A_CNT = 0, A_GREG = 1, A_CMPB = 2, A_CTRL = 3;
   localparam int A_IEN = 4, A_STA = 5, A_STB = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          rd_en = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          cap_in = 1'b0;
   logic          irq;

   int errs = 0;
   int checks = 0;
   bit done = 0;

   always #2 clk = ~clk;

   cctimer_chan #(.CNT_W(CW), .DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) i_cctimer_chan (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
      .wdata(wdata), .rdata(rdata), .cap_in(cap_in), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // all bus tasks start and end on a falling edge
   task automatic rd(input int a, output int v);
      addr = AW'(a); rd_en = 1'b1;
      #0.5 v = int'(rdata);
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic wr(input int a, input int d);
      addr = AW'(a); wdata = DW'(d); wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   // returns at the falling edge where the counter reads v
   task automatic wait_cnt(input int v);
      addr = AW'(A_CNT);
      forever begin
         #0.5;
         if (int'(rdata) == ((v - 1) & MASK)) begin
            @(negedge clk);
            break;
         end
         @(negedge clk);
      end
   endtask

   task automatic pulse_cap();
      cap_in = 1'b1;
      repeat (4) @(negedge clk);
      cap_in = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic irq_sweep(input int flags, input string req);
      for (int e = 0; e < 8; e++) begin
         wr(A_IEN, e);
         #0.5;
         chk(irq == ((e & flags) != 0), req, int'(irq), int'((e & flags) != 0));
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      int v, p;
      @(negedge clk);
      // R1: reset state
      repeat (2) @(negedge clk);
      for (int a = 0; a < 7; a++) begin
         addr = AW'(a);
         #0.5 chk(rdata == '0, "R1 register zero in reset", int'(rdata), 0);
      end
      chk(irq == 1'b0, "R1 irq low in reset", int'(irq), 0);
      @(negedge clk);
      rst_n = 1'b1;

      wr(A_GREG, 'h40);
      wr(A_CMPB, 'h60);

      // R2: counter steps by one and wraps
      addr = AW'(A_CNT);
      #0.5 p = int'(rdata);
      @(negedge clk);
      for (int i = 0; i < 300; i++) begin
         #0.5 v = int'(rdata);
         chk(v == ((p + 1) & MASK), "R2 counter step", v, (p + 1) & MASK);
         p = v;
         @(negedge clk);
      end

      // R2: overflow flag at the wrap
      wait_cnt('hF0);
      rd(A_STB, v); wr(A_STB, 'hFEFF);
      rd(A_STB, v);
      chk((v & 'h100) == 0, "R2 overflow cleared", v, 0);
      wait_cnt('hFF);
      rd(A_STB, v);
      chk((v & 'h100) == 0, "R2 overflow not early", v, 0);
      rd(A_STB, v);
      chk((v & 'h100) != 0, "R2 overflow on wrap", v, 'h100);

      // R4: compare match on general register
      wait_cnt('h30);
      rd(A_STA, v); wr(A_STA, 'hFFFE);
      rd(A_STA, v);
      chk(v == 0, "R4 general flag cleared", v, 0);
      wait_cnt('h40);
      rd(A_STA, v);
      chk(v == 0, "R4 flag not before match edge", v, 0);
      rd(A_STA, v);
      chk(v == 1, "R4 flag after match", v, 1);
      pulse_cap();
      rd(A_GREG, v);
      chk(v == 'h40, "R4 capture ignored in compare mode", v, 'h40);

      // R5: compare-only register
      wait_cnt('h50);
      rd(A_STB, v); wr(A_STB, 'hFFFE);
      rd(A_STB, v);
      chk((v & 1) == 0, "R5 match flag cleared", v, 0);
      wait_cnt('h60);
      rd(A_STB, v);
      chk((v & 1) == 0, "R5 match flag not early", v, 0);
      rd(A_STB, v);
      chk((v & 1) == 1, "R5 match flag set", v, 1);

      // R12: mode bit
      wr(A_CTRL, 'hFFFF);
      rd(A_CTRL, v);
      chk(v == 1, "R12 control readback", v, 1);

      // R3: capture sweep over counter positions
      for (int i = 0; i < 10; i++) begin
         int t;
         t = ('h10 + i * 23) & MASK;
         rd(A_STA, v); wr(A_STA, 'hFFFE);
         wait_cnt(t);
         cap_in = 1'b1;
         @(negedge clk); @(negedge clk);
         rd(A_STA, v);
         chk(v == 0, "R3 flag not before capture edge", v, 0);
         rd(A_GREG, v);
         chk(v == ((t + 2) & MASK), "R3 captured count", v, (t + 2) & MASK);
         rd(A_STA, v);
         chk(v == 1, "R3 flag on capture", v, 1);
         cap_in = 1'b0;
      end

      // R6: read-then-write-zero clears (flag is set and armed by last read)
      wr(A_STA, 0);
      rd(A_STA, v);
      chk(v == 0, "R6 handshake clear", v, 0);

      // R7: bare zero write does not clear
      pulse_cap();
      wr(A_STA, 0);
      rd(A_STA, v);
      chk(v == 1, "R7 zero without read", v, 1);
      wr(A_STA, 0);
      rd(A_STA, v);
      chk(v == 0, "R6 clear after read", v, 0);
      // R7: read of 0 does not arm
      rd(A_STA, v);
      pulse_cap();
      wr(A_STA, 0);
      rd(A_STA, v);
      chk(v == 1, "R7 read of zero does not arm", v, 1);

      // R8: write 1 keeps flag and disarms
      wr(A_STA, 'hFFFF);
      rd(A_STA, v);
      chk(v == 1, "R8 write one keeps flag", v, 1);
      wr(A_STA, 'hFFFF);
      wr(A_STA, 0);
      rd(A_STA, v);
      chk(v == 1, "R8 write one disarms", v, 1);
      wr(A_STA, 0);
      rd(A_STA, v);
      chk(v == 0, "R6 clear after fresh read", v, 0);

      // R10: set wins over simultaneous clear
      pulse_cap();
      rd(A_STA, v);
      chk(v == 1, "R10 flag set before race", v, 1);
      cap_in = 1'b1;
      @(negedge clk); @(negedge clk);
      wr(A_STA, 0);
      rd(A_STA, v);
      chk(v == 1, "R10 set beats clear", v, 1);
      cap_in = 1'b0;
      repeat (3) @(negedge clk);

      // R9: reserved bits
      wr(A_STB, 'hFFFF);
      rd(A_STB, v);
      chk((v & 'hFEFE) == 0, "R9 status B reserved after ones", v, v & 'h101);
      wr(A_STB, 0);
      rd(A_STB, v);
      chk((v & 'hFEFE) == 0, "R9 status B reserved after zeros", v, v & 'h101);
      wr(A_STA, 'hFFFF);
      rd(A_STA, v);
      chk((v & 'hFFFE) == 0, "R9 status A reserved", v, v & 1);

      // R11: interrupt enable sweep
      pulse_cap();
      wait_cnt('h10);
      wait_cnt('h70);
      rd(A_STB, v);
      chk(v == 'h101, "R11 precondition flags", v, 'h101);
      irq_sweep(7, "R11 all flags");
      rd(A_STA, v); wr(A_STA, 'hFFFE);
      irq_sweep(6, "R11 general cleared");
      rd(A_STB, v); wr(A_STB, 0);
      irq_sweep(0, "R11 all cleared");
      wr(A_IEN, 4);
      wait_cnt('h02);
      #0.5 chk(irq == 1'b1, "R11 overflow irq", int'(irq), 1);
      @(negedge clk);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule